// File: doc/BRIEF.md
# Receive Buffer Chain Checker and Ring Router

The block takes receive buffer descriptors, one 128-bit descriptor per valid/ready handshake, and turns runs of buffers that belong to the same MSDU into a single completion record. A set continuation bit on a buffer means the MSDU goes on in the next buffer. A clear bit closes the chain. Within a chain, the fields become valid in different buffers. The byte length and the buffer address are taken from the head buffer. The MPDU position flags, the destination index, the drop bit and the source/destination address search status are taken from the closing buffer.

Each completed MSDU goes to exactly one output ring, chosen by its destination index. An index with no native ring goes to a fallback ring set by a parameter. An MSDU that is marked for dropping goes nowhere. The block also keeps track of whether an MPDU is open. It reports ordering and encoding violations on a one-cycle error strobe carrying a code vector. An output ring that is not ready holds its record and stalls the input, so no descriptor is lost or duplicated.

Top module: `rx_chain_router`

## Requirements
- R1: Descriptor layout, with word k at in_desc[32k+31:32k]. Word 0 holds address bits 31:0. Word 1 [7:0] holds address bits 39:32. Word 2 holds the status: bit 0 first-in-MPDU, bit 1 last-in-MPDU, bit 2 continuation, [16:3] length, [21:17] destination, bit 22 drop, bit 23 SA valid, bit 24 SA timeout, bit 25 DA valid, bit 26 DA multicast, bit 27 DA timeout. Buffers up to and including the first one with continuation clear form one MSDU. That MSDU yields one record, with out_addr taken from the head buffer and out_nbuf equal to the number of buffers in the chain.
- R2: out_len is the length field of the head buffer. Length fields in later buffers of the chain are ignored.
- R3: out_flags are taken from the closing buffer only. The bits are [0] first, [1] last, [2] SA valid, [3] SA timeout, [4] DA valid, [5] DA multicast, [6] DA timeout.
- R4: out_flags[5] is 0 whenever DA valid is clear in the closing buffer, whatever the multicast bit holds.
- R5: A destination index below NUM_RINGS (default 9) raises only out_valid[index]. At most one out_valid bit is high at a time.
- R6: A destination index of NUM_RINGS or more raises out_valid[FALLBACK_RING] (default 5).
- R7: A completed MSDU whose closing buffer has the drop bit set produces no record on any ring.
- R8: A buffer with both last and continuation set gives err_code[0]. The buffer is still treated as a continuation buffer.
- R9: A completed MSDU marked first while an MPDU is already open gives err_code[1], and a new MPDU is started. After each completed MSDU, the MPDU is open exactly when that MSDU's last flag is clear.
- R10: A completed MSDU not marked first while no MPDU is open gives err_code[2].
- R11: A nonzero word 3 or a nonzero word 2 [31:28] gives err_code[3]. The buffer is otherwise processed normally.
- R12: err_valid and err_code describe the descriptor accepted at the previous clock edge. While a record waits on a ring that is not ready, the record holds steady and in_ready is low. Every record is delivered exactly once.
- R13: After reset, in_ready is 1, and out_valid and err_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor accepted this cycle when valid |
| in_desc | input | 128 | Descriptor, four 32-bit words |
| out_valid | output | NUM_RINGS | One-hot ring select of the pending record |
| out_ready | input | NUM_RINGS | Per-ring ready |
| out_addr | output | 40 | Head buffer address |
| out_len | output | 14 | MSDU length from the head buffer |
| out_nbuf | output | CNT_W | Buffers in the chain (saturating) |
| out_flags | output | 7 | Closing-buffer flags |
| err_valid | output | 1 | Error strobe |
| err_code | output | 4 | Error cause bits |

## Verification
The bench targets chains of three buffers whose middle and closing buffers carry conflicting lengths. A design that latched at the wrong end would report the wrong length or stale flags. It sends destinations just above and at the native limit, and a multicast bit with DA valid clear. A wrong remap or a missing mask shows up as a wrong ring or a stray flag bit. It also sends two MPDUs that are opened back to back, an orphan MSDU, a closing flag inside a chain, and a dropped MSDU. These check that each error bit fires on its own and that a dropped record never appears. Finally, one ring is held not ready while another descriptor waits. A design that ignored back-pressure would lose or duplicate a record, which the scoreboard would report as a mismatch or as leftover entries.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int DESC_W = 128;
   localparam int ADDR_W = 40;
   localparam int LEN_W  = 14;
   localparam int DEST_W = 5;
   localparam int FLAG_W = 7;
   localparam int ERR_W  = 4;

   // error cause bit positions
   localparam int E_LAST_IN_CHAIN = 0;
   localparam int E_REOPEN        = 1;
   localparam int E_ORPHAN        = 2;
   localparam int E_RESERVED      = 3;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic              first;
      logic              last;
      logic              cont;
      logic [LEN_W-1:0]  len;
      logic [DEST_W-1:0] dest;
      logic              drop;
      logic              sa_ok;
      logic              sa_late;
      logic              da_ok;
      logic              da_group;
      logic              da_late;
      logic              rsvd_bad;
   } rxr_fields_t;
endpackage

// File: rtl/rxr_desc_decode.sv
module rxr_desc_decode
   import rxr_pkg::*;
(
   input  logic [DESC_W-1:0] desc,
   output rxr_fields_t       fld
);
   logic [31:0] w0, w1, w2, w3;

   always_comb begin
      w0 = desc[31:0];
      w1 = desc[63:32];
      w2 = desc[95:64];
      w3 = desc[127:96];
      fld.addr     = {w1[7:0], w0};
      fld.first    = w2[0];
      fld.last     = w2[1];
      fld.cont     = w2[2];
      fld.len      = w2[16:3];
      fld.dest     = w2[21:17];
      fld.drop     = w2[22];
      fld.sa_ok    = w2[23];
      fld.sa_late  = w2[24];
      fld.da_ok    = w2[25];
      fld.da_group = w2[26];
      fld.da_late  = w2[27];
      fld.rsvd_bad = (|w2[31:28]) | (|w3);
   end
endmodule

// File: rtl/rxr_chain_tracker.sv
module rxr_chain_tracker
   import rxr_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  rxr_fields_t       fld,
   output logic              done,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [LEN_W-1:0]  rec_len,
   output logic [CNT_W-1:0]  rec_nbuf,
   output logic [FLAG_W-1:0] rec_flags,
   output logic              err_valid,
   output logic [ERR_W-1:0]  err_code
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic              in_chain_q;
   logic              mpdu_open_q;
   logic [ADDR_W-1:0] head_addr_q;
   logic [LEN_W-1:0]  head_len_q;
   logic [CNT_W-1:0]  nbuf_q;
   logic [ERR_W-1:0]  err_d;
   logic              head;

   always_comb begin
      head      = !in_chain_q;
      done      = acc && !fld.cont;
      rec_addr  = head ? fld.addr : head_addr_q;
      rec_len   = head ? fld.len  : head_len_q;
      if (head)                 rec_nbuf = CNT_W'(1);
      else if (nbuf_q == CNT_MAX) rec_nbuf = CNT_MAX;
      else                      rec_nbuf = nbuf_q + CNT_W'(1);
      rec_flags = {fld.da_late, fld.da_group & fld.da_ok, fld.da_ok,
                   fld.sa_late, fld.sa_ok, fld.last, fld.first};
      err_d                  = '0;
      err_d[E_LAST_IN_CHAIN] = acc && fld.cont && fld.last;
      err_d[E_REOPEN]        = done && fld.first && mpdu_open_q;
      err_d[E_ORPHAN]        = done && !fld.first && !mpdu_open_q;
      err_d[E_RESERVED]      = acc && fld.rsvd_bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_chain_q  <= 1'b0;
         mpdu_open_q <= 1'b0;
         head_addr_q <= '0;
         head_len_q  <= '0;
         nbuf_q      <= '0;
         err_valid   <= 1'b0;
         err_code    <= '0;
      end else begin
         err_valid <= |err_d;
         err_code  <= err_d;
         if (acc) begin
            if (head) begin
               head_addr_q <= fld.addr;
               head_len_q  <= fld.len;
            end
            nbuf_q     <= rec_nbuf;
            in_chain_q <= fld.cont;
            if (done) mpdu_open_q <= !fld.last;
         end
      end
   end
endmodule

// File: rtl/rxr_ring_map.sv
module rxr_ring_map
   import rxr_pkg::*;
#(
   parameter int NUM_RINGS     = 9,
   parameter int FALLBACK_RING = 5,
   parameter int RING_W        = 4
) (
   input  logic [DEST_W-1:0] dest,
   output logic [RING_W-1:0] ring
);
   generate
      if (NUM_RINGS >= (1 << DEST_W)) begin : g_direct
         assign ring = RING_W'(dest);
      end else begin : g_remap
         assign ring = (int'(dest) < NUM_RINGS) ? RING_W'(dest) : RING_W'(FALLBACK_RING);
      end
   endgenerate
endmodule

// File: rtl/rx_chain_router.sv
module rx_chain_router
   import rxr_pkg::*;
#(
   parameter int NUM_RINGS     = 9,
   parameter int FALLBACK_RING = 5,
   parameter int CNT_W         = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [127:0]         in_desc,
   output logic [NUM_RINGS-1:0] out_valid,
   input  logic [NUM_RINGS-1:0] out_ready,
   output logic [39:0]          out_addr,
   output logic [13:0]          out_len,
   output logic [CNT_W-1:0]     out_nbuf,
   output logic [6:0]           out_flags,
   output logic                 err_valid,
   output logic [3:0]           err_code
);
   localparam int RING_W = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1;

   generate
      if (NUM_RINGS < 1 || NUM_RINGS > 32) begin : g_bad_rings
         $error("NUM_RINGS must lie in 1..32");
      end
      if (FALLBACK_RING < 0 || FALLBACK_RING >= NUM_RINGS) begin : g_bad_fb
         $error("FALLBACK_RING must name an existing ring");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   rxr_fields_t       fld;
   logic              acc, done, load, pop, full_q;
   logic [ADDR_W-1:0] rec_addr;
   logic [LEN_W-1:0]  rec_len;
   logic [CNT_W-1:0]  rec_nbuf;
   logic [FLAG_W-1:0] rec_flags;
   logic [RING_W-1:0] ring_d, ring_q;

   rxr_desc_decode i_decode (.desc(in_desc), .fld(fld));

   rxr_chain_tracker #(.CNT_W(CNT_W)) i_track (
      .clk(clk), .rst_n(rst_n), .acc(acc), .fld(fld), .done(done),
      .rec_addr(rec_addr), .rec_len(rec_len), .rec_nbuf(rec_nbuf),
      .rec_flags(rec_flags), .err_valid(err_valid), .err_code(err_code)
   );

   rxr_ring_map #(.NUM_RINGS(NUM_RINGS), .FALLBACK_RING(FALLBACK_RING), .RING_W(RING_W))
      i_map (.dest(fld.dest), .ring(ring_d));

   for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
      assign out_valid[g] = full_q && (ring_q == RING_W'(g));
   end

   assign pop      = |(out_valid & out_ready);
   assign in_ready = !full_q || pop;
   assign acc      = in_valid && in_ready;
   assign load     = done && !fld.drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q    <= 1'b0;
         ring_q    <= '0;
         out_addr  <= '0;
         out_len   <= '0;
         out_nbuf  <= '0;
         out_flags <= '0;
      end else if (load) begin
         full_q    <= 1'b1;
         ring_q    <= ring_d;
         out_addr  <= rec_addr;
         out_len   <= rec_len;
         out_nbuf  <= rec_nbuf;
         out_flags <= rec_flags;
      end else if (pop) begin
         full_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
   parameter int NUM_RINGS     = 9,
   parameter int FALLBACK_RING = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic [127:0]         in_desc,
   input logic [NUM_RINGS-1:0] out_valid,
   input logic [NUM_RINGS-1:0] out_ready,
   input logic [39:0]          out_addr,
   input logic [13:0]          out_len,
   input logic                 err_valid,
   input logic [3:0]           err_code
);
   localparam logic [NUM_RINGS-1:0] FB_HOT = NUM_RINGS'(1) << FALLBACK_RING;

   logic acc, stalled;
   assign acc     = in_valid && in_ready;
   assign stalled = (|out_valid) && !(|(out_valid & out_ready));

   // R5
   one_ring_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(out_valid));

   // R12
   hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |=> (out_valid == $past(out_valid)) && $stable(out_addr) && $stable(out_len));

   // R12
   stall_input_chk: assert property (@(posedge clk) disable iff (!rst_n) stalled |-> !in_ready);

   // R8
   last_in_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_desc[65] && in_desc[66]) |=> (err_valid && err_code[0]));

   // R7
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_desc[66] && in_desc[86]) |=> (out_valid == '0));

   // R6
   fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_desc[66] && !in_desc[86] && (int'(in_desc[85:81]) >= NUM_RINGS))
      |=> (out_valid == FB_HOT));

   // R11
   reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ((|in_desc[127:96]) || (|in_desc[95:92]))) |=> (err_valid && err_code[3]));
endmodule

bind rx_chain_router rxr_checker #(.NUM_RINGS(NUM_RINGS), .FALLBACK_RING(FALLBACK_RING)) i_rxr_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_desc(in_desc),
   .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_len(out_len),
   .err_valid(err_valid), .err_code(err_code)
);

// File: tb/test_rx_chain_router.sv
`timescale 1ns/1ps
module test_rx_chain_router;
   localparam int NR = 9;
   localparam int FB = 5;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [127:0]  in_desc = '0;
   logic [NR-1:0] out_valid;
   logic [NR-1:0] out_ready = '1;
   logic [39:0]   out_addr;
   logic [13:0]   out_len;
   logic [CW-1:0] out_nbuf;
   logic [6:0]    out_flags;
   logic          err_valid;
   logic [3:0]    err_code;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   rx_chain_router #(.NUM_RINGS(NR), .FALLBACK_RING(FB), .CNT_W(CW)) i_rx_chain_router (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_desc(in_desc),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_len(out_len),
      .out_nbuf(out_nbuf), .out_flags(out_flags), .err_valid(err_valid), .err_code(err_code)
   );

   // expected record: ring(4) addr(40) len(14) nbuf(6) flags(7)
   logic [70:0] exp_q[$];
   string       tag_q[$];

   // reference state derived from the requirements
   bit          m_chain = 0;
   bit          m_open  = 0;
   logic [39:0] m_addr;
   logic [13:0] m_len;
   int          m_nbuf = 0;

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // st = {da_late, da_group, da_ok, sa_late, sa_ok}
   task automatic send(input logic [39:0] addr, input bit cont, input bit first, input bit last,
                       input logic [13:0] len, input logic [4:0] dest, input bit drop,
                       input logic [4:0] st, input logic [31:0] w3, input logic [3:0] w2hi,
                       input string tag);
      logic [31:0] w2;
      logic [3:0]  e;
      logic [6:0]  fl;
      logic [3:0]  ring;
      bit          done;
      w2 = {w2hi, st[4], st[3], st[2], st[1], st[0], drop, dest, len, cont, last, first};
      in_desc  = {w3, w2, 24'h0, addr[39:32], addr[31:0]};
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      done = !cont;
      e[0] = cont && last;
      e[1] = done && first && m_open;
      e[2] = done && !first && !m_open;
      e[3] = (w3 != 0) || (w2hi != 0);
      if (!m_chain) begin
         m_addr = addr;
         m_len  = len;
         m_nbuf = 1;
      end else if (m_nbuf < 63) begin
         m_nbuf++;
      end
      m_chain = cont;
      if (done) begin
         m_open = !last;
         fl = {st[4], st[3] & st[2], st[2], st[1], st[0], last, first};
         ring = (dest < NR) ? dest[3:0] : 4'(FB);
         if (!drop) begin
            exp_q.push_back({ring, m_addr, m_len, 6'(m_nbuf), fl});
            tag_q.push_back(tag);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      check((err_valid == (e != 0)) && (err_code == e), {tag, " R12 err"},
            {err_valid, err_code}, {e != 0, e});
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && |(out_valid & out_ready)) begin
         logic [3:0]  r;
         logic [70:0] act, exp;
         string       t;
         r = 0;
         for (int i = 0; i < NR; i++) if (out_valid[i]) r = 4'(i);
         act = {r, out_addr, out_len, out_nbuf, out_flags};
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected record", act, 0);
         end else begin
            exp = exp_q.pop_front();
            t   = tag_q.pop_front();
            check(act == exp && $onehot(out_valid), t, act, exp);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R12 watchdog actual=hang expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13 reset state
      check(in_ready == 1 && out_valid == 0 && err_valid == 0, "R13 reset", {in_ready, out_valid, err_valid}, 11'h400);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1 && out_valid == 0 && err_valid == 0, "R13 after release", {in_ready, out_valid, err_valid}, 11'h400);

      // R1 R5 single-buffer MPDU to ring 2
      send(40'h12_3456_789A, 0, 1, 1, 14'd64, 5'd2, 0, 5'b00001, 0, 0, "R1 R5 single");
      // R2 R3 three-buffer chain, conflicting later lengths, flags from closer
      send(40'hAB_0000_1000, 1, 0, 0, 14'd1000, 5'd31, 0, 5'b11111, 0, 0, "R2 head");
      send(40'hAB_0000_2000, 1, 1, 0, 14'd77,   5'd0,  1, 5'b00000, 0, 0, "R2 mid");
      send(40'hAB_0000_3000, 0, 1, 1, 14'd5,    5'd7,  0, 5'b10101, 0, 0, "R2 R3 R1 chain of three");
      // R9 two MSDUs in one MPDU, no error
      send(40'h00_0000_0100, 0, 1, 0, 14'd10, 5'd8, 0, 5'b00000, 0, 0, "R5 ring8 open");
      send(40'h00_0000_0200, 0, 0, 1, 14'd11, 5'd1, 0, 5'b00000, 0, 0, "R9 close");
      // R6 fallback for 9 and 20
      send(40'h00_0000_0300, 0, 1, 1, 14'd12, 5'd9,  0, 5'b00000, 0, 0, "R6 dest9");
      send(40'h00_0000_0400, 0, 1, 1, 14'd13, 5'd20, 0, 5'b00000, 0, 0, "R6 dest20");
      // R4 multicast masked without DA valid, kept with it
      send(40'h00_0000_0500, 0, 1, 1, 14'd14, 5'd3, 0, 5'b01000, 0, 0, "R4 masked");
      send(40'h00_0000_0600, 0, 1, 1, 14'd15, 5'd3, 0, 5'b01100, 0, 0, "R4 kept");
      // R7 dropped chain of two
      send(40'h00_0000_0700, 1, 0, 0, 14'd16, 5'd4, 0, 5'b00000, 0, 0, "R7 head");
      send(40'h00_0000_0800, 0, 1, 1, 14'd17, 5'd4, 1, 5'b00000, 0, 0, "R7 drop");
      repeat (2) @(negedge clk);
      check(out_valid == 0, "R7 no output", out_valid, 0);
      // R8 last flag inside a chain
      send(40'h00_0000_0900, 1, 1, 1, 14'd18, 5'd0, 0, 5'b00000, 0, 0, "R8 last with cont");
      send(40'h00_0000_0A00, 0, 1, 1, 14'd19, 5'd6, 0, 5'b00000, 0, 0, "R8 closing");
      // R9 reopen while open
      send(40'h00_0000_0B00, 0, 1, 0, 14'd20, 5'd0, 0, 5'b00000, 0, 0, "R9 open");
      send(40'h00_0000_0C00, 0, 1, 1, 14'd21, 5'd0, 0, 5'b00000, 0, 0, "R9 reopen");
      // R10 orphan
      send(40'h00_0000_0D00, 0, 0, 1, 14'd22, 5'd1, 0, 5'b00000, 0, 0, "R10 orphan");
      // R11 reserved bits
      send(40'h00_0000_0E00, 0, 1, 1, 14'd23, 5'd2, 0, 5'b00000, 32'h1, 0, "R11 word3");
      send(40'h00_0000_0F00, 0, 1, 1, 14'd24, 5'd2, 0, 5'b00000, 0, 4'h8, "R11 word2 top");
      // R12 back-pressure on ring 3
      out_ready[3] = 1'b0;
      send(40'h00_0000_1100, 0, 1, 1, 14'd25, 5'd3, 0, 5'b00000, 0, 0, "R12 held");
      fork
         send(40'h00_0000_1200, 0, 1, 1, 14'd26, 5'd1, 0, 5'b00000, 0, 0, "R12 waiting");
         begin
            for (int k = 0; k < 4; k++) begin
               @(negedge clk);
               check(in_ready == 0 && out_valid == 9'h008 && out_len == 14'd25, "R12 stall",
                     {in_ready, out_valid, out_len}, {1'b0, 9'h008, 14'd25});
            end
            @(posedge clk);
            #1 out_ready[3] = 1'b1;
         end
      join
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R12 all delivered", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule